// File: doc/BRIEF.md
# Two-Level Error Status Logger

This block keeps the error status of one error group inside a packet interface controller. Thirty-two error sources send it single-cycle pulses. The status word has two flags per source. The first logged occurrence of an error raises its first-occurrence flag. A repeat of the same error while that flag is still up raises its repeat flag. Recording is gated per source by a log-enable mask. A separate interrupt-enable mask covers both flag halves and drives a single group interrupt summary.

The block also keeps a 128-bit header of the offending received packet and a 128-bit header of the transmitted request tied to it. Both headers are loaded when a first-occurrence flag is raised while no other first-occurrence flag remains set. They then hold still until software has cleared every first-occurrence flag. A header whose format field says it has three dwords is stored with its unused last dword forced to zero.

Software uses a small register port. It has one write channel, which clears status flags by writing ones and loads the enable masks. It has one independent combinational read channel. Error detection, header parsing and the chip-level interrupt controller are outside this block.

Top module: `err_group_logger`

## Requirements
- R1: The status word, read at address 0, holds the first-occurrence flag of error index i at bit i (bits 31:0) and the repeat flag of the same index at bit 32+i (bits 63:32).
- R2: A logged error pulse on index i sets first-occurrence bit i if it is clear. If bit i is already set, the pulse sets repeat bit 32+i instead. The flags are visible one clock after the pulse.
- R3: The log-enable mask (address 1, bits 31:0) gates both flags of each index. A pulse on a disabled index changes no status bit.
- R4: Writing address 0 clears every status bit written as 1 and leaves bits written as 0 unchanged. First-occurrence and repeat bits clear independently in the same write.
- R5: The interrupt output is high exactly when some status bit and the same bit of the 64-bit interrupt-enable mask (address 2) are both set. It reflects the registers updated at the previous clock edge.
- R6: The received header (address 3 = bits 127:64, address 4 = bits 63:0) and the transmitted header (address 5 = bits 127:64, address 6 = bits 63:0) are loaded in the clock in which a first-occurrence bit is set and no other first-occurrence bit survives that clock's clear.
- R7: While any first-occurrence bit remains set, both captured headers hold their value.
- R8: Each header is judged by its own bit 125. If that bit is 0 (three-dword header), bits 31:0 are stored as zero. If it is 1, all 128 bits are stored.
- R9: Error index 11 is first-occurrence only. Its repeat bit 43 never sets.
- R10: When an error pulse and a clear of the bit that pulse sets fall in the same clock, the bit is set after that clock.
- R11: Synchronous reset returns status, both masks and both headers to zero, and the interrupt output is low.
- R12: Header addresses 3 to 6 ignore writes. Bits 63:32 of address 1 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_i | input | 32 | Error pulses, one per index |
| rx_hdr_i | input | 128 | Header of the offending received packet |
| tx_hdr_i | input | 128 | Header of the associated transmitted request |
| csr_we_i | input | 1 | Register write strobe |
| csr_waddr_i | input | 3 | Register write address |
| csr_wdata_i | input | 64 | Register write data |
| csr_raddr_i | input | 3 | Register read address |
| csr_rdata_o | output | 64 | Register read data (combinational) |
| irq_o | output | 1 | Group interrupt summary |

## Verification
The assertions assume that the error pulses, headers and write-port inputs are known, non-X values at every clock edge after reset. They also assume that the write address stays within the seven defined registers when it matters. The stimulus drives every input to a defined value from time zero and changes inputs only between clock edges. It holds reset through the first edges, so every past-value check starts from a zeroed state. Random write addresses are drawn from the defined range only, and the directed phase places clears and pulses in the same clock on purpose to reach the same-cycle rules.

// File: rtl/errlog_pkg.sv
`timescale 1ns/1ps
package errlog_pkg;

    localparam int ERR_N  = 32;
    localparam int HDR_W  = 128;
    localparam int CSR_W  = 2 * ERR_N;
    localparam int ADDR_W = 3;
    localparam int HALF_W = HDR_W / 2;
    localparam int DW_W   = 32;

    typedef enum logic [ADDR_W-1:0] {
        ADR_STATUS = 3'd0,
        ADR_LOGEN  = 3'd1,
        ADR_INTEN  = 3'd2,
        ADR_RXHI   = 3'd3,
        ADR_RXLO   = 3'd4,
        ADR_TXHI   = 3'd5,
        ADR_TXLO   = 3'd6
    } csr_addr_e;

    // Repeat flags occupy the upper half, first-occurrence flags the lower half.
    typedef struct packed {
        logic [ERR_N-1:0] rep;
        logic [ERR_N-1:0] first;
    } status_t;

    // A header with its long-format bit low keeps only its upper three dwords.
    function automatic logic [HDR_W-1:0] trim_hdr(input logic [HDR_W-1:0] h,
                                                  input int unsigned long_bit);
        logic [HDR_W-1:0] r;
        r = h;
        if (!h[long_bit]) r[DW_W-1:0] = '0;
        return r;
    endfunction

endpackage

// File: rtl/errlog_status_bank.sv
`timescale 1ns/1ps
module errlog_status_bank
    import errlog_pkg::*;
#(
    parameter int ONLY_FIRST_IDX = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ERR_N-1:0] err_log,
    input  status_t          clr,
    output status_t          stat,
    output logic             cap_en
);

    logic [ERR_N-1:0] set_first;
    logic [ERR_N-1:0] set_rep;
    logic [ERR_N-1:0] keep_first;

    for (genvar i = 0; i < ERR_N; i++) begin : g_bit
        assign set_first[i] = err_log[i] & ~stat.first[i];
        if (i == ONLY_FIRST_IDX) begin : g_only_first
            assign set_rep[i] = 1'b0;
        end else begin : g_two_level
            assign set_rep[i] = err_log[i] & stat.first[i];
        end
    end

    assign keep_first = stat.first & ~clr.first;
    assign cap_en     = (|set_first) && (keep_first == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else begin
            stat.first <= keep_first | set_first;
            stat.rep   <= (stat.rep & ~clr.rep) | set_rep;
        end
    end

    AST_FIRST_ON_NEW: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat.first & $past(err_log & ~stat.first)) == $past(err_log & ~stat.first))); // R2

    AST_REP_ON_AGAIN: assert property (@(posedge clk) disable iff (rst)
        (err_log[0] && stat.first[0]) |=> stat.rep[0]); // R2

    AST_W1C_FIRST: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat.first & $past(clr.first & ~err_log)) == '0)); // R4

    AST_ONLY_FIRST_IDX: assert property (@(posedge clk) disable iff (rst)
        err_log[ONLY_FIRST_IDX] |=> !stat.rep[ONLY_FIRST_IDX]); // R9

    AST_ERR_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (err_log[1] && stat.first[1] && clr.rep[1]) |=> stat.rep[1]); // R10

endmodule

// File: rtl/errlog_hdr_capture.sv
`timescale 1ns/1ps
module errlog_hdr_capture
    import errlog_pkg::*;
#(
    parameter int unsigned LONG_BIT = 125
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_en,
    input  logic [HDR_W-1:0] hdr_in,
    output logic [HDR_W-1:0] hdr_q
);

    always_ff @(posedge clk) begin
        if (rst)         hdr_q <= '0;
        else if (cap_en) hdr_q <= trim_hdr(hdr_in, LONG_BIT);
    end

    AST_HDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(hdr_q)); // R7

    AST_SHORT_HDR_LOW: assert property (@(posedge clk) disable iff (rst)
        (cap_en && !hdr_in[LONG_BIT]) |=> (hdr_q[DW_W-1:0] == '0)); // R8

endmodule

// File: rtl/errlog_csr.sv
`timescale 1ns/1ps
module errlog_csr
    import errlog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [CSR_W-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    input  status_t           stat,
    input  logic [HDR_W-1:0]  rx_q,
    input  logic [HDR_W-1:0]  tx_q,
    output logic [ERR_N-1:0]  log_en,
    output logic [CSR_W-1:0]  int_en,
    output status_t           clr,
    output logic [CSR_W-1:0]  rdata
);

    assign clr = (we && csr_addr_e'(waddr) == ADR_STATUS) ? status_t'(wdata) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            log_en <= '0;
            int_en <= '0;
        end else if (we) begin
            if (csr_addr_e'(waddr) == ADR_LOGEN) log_en <= wdata[ERR_N-1:0];
            if (csr_addr_e'(waddr) == ADR_INTEN) int_en <= wdata;
        end
    end

    always_comb begin
        case (csr_addr_e'(raddr))
            ADR_STATUS: rdata = stat;
            ADR_LOGEN:  rdata = {{(CSR_W-ERR_N){1'b0}}, log_en};
            ADR_INTEN:  rdata = int_en;
            ADR_RXHI:   rdata = rx_q[HDR_W-1:HALF_W];
            ADR_RXLO:   rdata = rx_q[HALF_W-1:0];
            ADR_TXHI:   rdata = tx_q[HDR_W-1:HALF_W];
            ADR_TXLO:   rdata = tx_q[HALF_W-1:0];
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/err_group_logger.sv
`timescale 1ns/1ps
module err_group_logger
    import errlog_pkg::*;
#(
    parameter int          ONLY_FIRST_IDX = 11,
    parameter int unsigned LONG_BIT       = 125
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ERR_N-1:0]  err_i,
    input  logic [HDR_W-1:0]  rx_hdr_i,
    input  logic [HDR_W-1:0]  tx_hdr_i,
    input  logic              csr_we_i,
    input  logic [ADDR_W-1:0] csr_waddr_i,
    input  logic [CSR_W-1:0]  csr_wdata_i,
    input  logic [ADDR_W-1:0] csr_raddr_i,
    output logic [CSR_W-1:0]  csr_rdata_o,
    output logic              irq_o
);

    status_t          stat;
    status_t          clr;
    logic [ERR_N-1:0] log_en;
    logic [CSR_W-1:0] int_en;
    logic [ERR_N-1:0] err_log;
    logic             cap_en;
    logic [HDR_W-1:0] rx_q;
    logic [HDR_W-1:0] tx_q;

    assign err_log = err_i & log_en;

    errlog_csr u_csr (
        .clk    (clk),
        .rst    (rst),
        .we     (csr_we_i),
        .waddr  (csr_waddr_i),
        .wdata  (csr_wdata_i),
        .raddr  (csr_raddr_i),
        .stat   (stat),
        .rx_q   (rx_q),
        .tx_q   (tx_q),
        .log_en (log_en),
        .int_en (int_en),
        .clr    (clr),
        .rdata  (csr_rdata_o)
    );

    errlog_status_bank #(.ONLY_FIRST_IDX(ONLY_FIRST_IDX)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .err_log (err_log),
        .clr     (clr),
        .stat    (stat),
        .cap_en  (cap_en)
    );

    errlog_hdr_capture #(.LONG_BIT(LONG_BIT)) u_rx_cap (
        .clk    (clk),
        .rst    (rst),
        .cap_en (cap_en),
        .hdr_in (rx_hdr_i),
        .hdr_q  (rx_q)
    );

    errlog_hdr_capture #(.LONG_BIT(LONG_BIT)) u_tx_cap (
        .clk    (clk),
        .rst    (rst),
        .cap_en (cap_en),
        .hdr_in (tx_hdr_i),
        .hdr_q  (tx_q)
    );

    assign irq_o = |(stat & int_en);

    AST_MASKED_NO_SET: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat.first & ~$past(stat.first) & ~$past(err_i & log_en)) == '0)); // R3

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (int_en == '0) |-> !irq_o); // R5

    AST_RESET_CLEAN: assert property (@(posedge clk)
        $past(rst) |-> (stat == '0 && rx_q == '0 && tx_q == '0)); // R11

endmodule

// File: tb/err_group_logger_tb.sv
`timescale 1ns/1ps
module err_group_logger_tb_top;

    logic         clk = 1'b0;
    logic         s_rst = 1'b1;
    logic [31:0]  s_err = '0;
    logic [127:0] s_rx = '0;
    logic [127:0] s_tx = '0;
    logic         s_we = 1'b0;
    logic [2:0]   s_wa = '0;
    logic [63:0]  s_wd = '0;
    logic [2:0]   s_ra = '0;
    logic [63:0]  rdata;
    logic         irq;

    int n_chk = 0;
    int n_fail = 0;

    // reference state
    logic [31:0]  m_first, m_rep, m_len;
    logic [63:0]  m_ien;
    logic [127:0] m_rx, m_tx;

    always #5 clk = ~clk;

    err_group_logger dut_i (
        .clk         (clk),
        .rst         (s_rst),
        .err_i       (s_err),
        .rx_hdr_i    (s_rx),
        .tx_hdr_i    (s_tx),
        .csr_we_i    (s_we),
        .csr_waddr_i (s_wa),
        .csr_wdata_i (s_wd),
        .csr_raddr_i (s_ra),
        .csr_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic report_end();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [127:0] cut(input logic [127:0] h);
        logic [127:0] r = h;
        if (h[125] == 1'b0) r[31:0] = 32'h0;
        return r;
    endfunction

    function automatic logic [63:0] m_read(input int a);
        case (a)
            0: return {m_rep, m_first};
            1: return {32'h0, m_len};
            2: return m_ien;
            3: return m_rx[127:64];
            4: return m_rx[63:0];
            5: return m_tx[127:64];
            6: return m_tx[63:0];
            default: return 64'h0;
        endcase
    endfunction

    task automatic m_clear();
        m_first = '0; m_rep = '0; m_len = '0; m_ien = '0; m_rx = '0; m_tx = '0;
    endtask

    task automatic m_update();
        logic [31:0] cf, cr, nf, nr, left;
        cf = (s_we && s_wa == 3'd0) ? s_wd[31:0]  : 32'h0;
        cr = (s_we && s_wa == 3'd0) ? s_wd[63:32] : 32'h0;
        nf = '0; nr = '0;
        for (int i = 0; i < 32; i++) begin
            if (s_err[i] && m_len[i]) begin
                if (!m_first[i]) nf[i] = 1'b1;
                else if (i != 11) nr[i] = 1'b1;
            end
        end
        left = m_first & ~cf;
        if (nf != 0 && left == 0) begin
            m_rx = cut(s_rx);
            m_tx = cut(s_tx);
        end
        m_first = left | nf;
        m_rep   = (m_rep & ~cr) | nr;
        if (s_we && s_wa == 3'd1) m_len = s_wd[31:0];
        if (s_we && s_wa == 3'd2) m_ien = s_wd;
    endtask

    task automatic compare_all();
        string tags [7] = '{"R1", "R3", "R5", "R6", "R6", "R6", "R6"};
        for (int a = 0; a < 7; a++) begin
            s_ra = 3'(a);
            #0.2;
            chk($sformatf("%s model addr %0d", tags[a], a), rdata, m_read(a));
        end
        chk("R5 model irq", {63'h0, irq}, {63'h0, (({m_rep, m_first} & m_ien) != 0)});
    endtask

    task automatic step();
        @(posedge clk);
        if (s_rst) m_clear();
        else m_update();
        #1;
        compare_all();
    endtask

    task automatic idle();
        s_err = '0; s_we = 1'b0; s_wa = '0; s_wd = '0;
    endtask

    task automatic cyc(input logic [31:0] e, input logic we, input logic [2:0] wa,
                       input logic [63:0] wd, input logic [127:0] rx, input logic [127:0] tx);
        s_err = e; s_we = we; s_wa = wa; s_wd = wd; s_rx = rx; s_tx = tx;
        step();
        idle();
    endtask

    task automatic expect_rd(input int a, input logic [63:0] exp, input string tag);
        s_ra = 3'(a);
        #0.2;
        chk(tag, rdata, exp);
    endtask

    localparam logic [127:0] H1 = 128'h2A00_0004_1111_2222_3333_4444_5555_6666;
    localparam logic [127:0] H2 = 128'h2A00_0004_7777_8888_9999_AAAA_BBBB_CCCC;
    localparam logic [127:0] H3 = 128'h4A00_0003_0102_0304_0506_0708_DEAD_BEEF;
    localparam logic [127:0] T1 = 128'h2B00_0001_AAAA_0001_BBBB_0002_CCCC_0003;
    localparam logic [127:0] T2 = 128'h0B00_0002_ABAB_0101_CDCD_0202_EFEF_0303;

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual running expected finished");
        report_end();
    end

    initial begin
        m_clear();
        step(); step(); step();
        for (int a = 0; a < 7; a++) expect_rd(a, 64'h0, "R11 reset value");
        chk("R11 reset irq", {63'h0, irq}, 64'h0);
        s_rst = 1'b0;

        cyc('0, 1'b1, 3'd1, 64'hFFFF_FFFF, '0, '0);
        cyc('0, 1'b1, 3'd2, 64'h0, '0, '0);

        cyc(32'h8, 1'b0, 3'd0, '0, H1, T1);
        expect_rd(0, 64'h0000_0000_0000_0008, "R2 first flag");
        expect_rd(3, H1[127:64], "R6 rx hi");
        expect_rd(4, H1[63:0],   "R6 rx lo");
        expect_rd(6, T1[63:0],   "R6 tx lo");

        cyc(32'h8, 1'b0, 3'd0, '0, H2, T2);
        expect_rd(0, 64'h0000_0008_0000_0008, "R2 repeat flag");
        expect_rd(3, H1[127:64], "R7 rx held");
        expect_rd(5, T1[127:64], "R7 tx held");

        cyc(32'h800, 1'b0, 3'd0, '0, H2, T2);
        cyc(32'h800, 1'b0, 3'd0, '0, H2, T2);
        expect_rd(0, 64'h0000_0008_0000_0808, "R9 index 11 no repeat");

        cyc('0, 1'b1, 3'd2, 64'h0000_0008_0000_0000, '0, '0);
        chk("R5 irq on enabled repeat", {63'h0, irq}, 64'h1);

        cyc('0, 1'b1, 3'd0, 64'h0000_0000_0000_0008, '0, '0);
        expect_rd(0, 64'h0000_0008_0000_0800, "R4 clear first only");

        cyc('0, 1'b1, 3'd1, 64'hFFFF_FF7F, '0, '0);
        cyc(32'h80, 1'b0, 3'd0, '0, H2, T2);
        expect_rd(0, 64'h0000_0008_0000_0800, "R3 masked error ignored");

        cyc(32'h8, 1'b0, 3'd0, '0, H2, T2);
        expect_rd(0, 64'h0000_0008_0000_0808, "R2 first again");
        expect_rd(4, H1[63:0], "R7 no load with first flags up");

        cyc(32'h8, 1'b1, 3'd0, 64'h0000_0008_0000_0000, H2, T2);
        expect_rd(0, 64'h0000_0008_0000_0808, "R10 error beats clear");

        cyc('0, 1'b1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, '0, '0);
        expect_rd(0, 64'h0, "R4 clear all");
        chk("R5 irq drops", {63'h0, irq}, 64'h0);

        cyc(32'h0010_0000, 1'b0, 3'd0, '0, H3, T1);
        expect_rd(4, {H3[63:32], 32'h0}, "R8 short header low dword");
        expect_rd(6, T1[63:0], "R8 long header kept");

        cyc(32'h20, 1'b1, 3'd0, 64'h0000_0000_0010_0000, H1, T2);
        expect_rd(0, 64'h20, "R1 status layout");
        expect_rd(3, H1[127:64], "R6 load after same-cycle clear");

        cyc('0, 1'b1, 3'd3, 64'hFFFF_FFFF_FFFF_FFFF, '0, '0);
        expect_rd(3, H1[127:64], "R12 header write ignored");
        cyc('0, 1'b1, 3'd1, 64'hFFFF_FFFF_FFFF_FFFF, '0, '0);
        expect_rd(1, 64'h0000_0000_FFFF_FFFF, "R12 log enable upper zero");

        for (int n = 0; n < 3000; n++) begin
            logic [63:0] wd;
            logic        we;
            wd = {$urandom, $urandom};
            we = ($urandom % 6) == 0;
            s_err = $urandom & $urandom & $urandom;
            s_rx  = {$urandom, $urandom, $urandom, $urandom};
            s_tx  = {$urandom, $urandom, $urandom, $urandom};
            s_we  = we;
            s_wa  = 3'($urandom % 7);
            s_wd  = (s_wa == 3'd0) ? (wd & {$urandom, $urandom}) : wd;
            step();
            idle();
        end

        s_rst = 1'b1;
        step(); step();
        s_rst = 1'b0;
        for (int a = 0; a < 7; a++) expect_rd(a, 64'h0, "R11 mid-run reset");
        chk("R11 irq after reset", {63'h0, irq}, 64'h0);

        report_end();
    end

endmodule